// File: doc/BRIEF.md
# Serial-Serial Partial Product Row Generator

This block is the front end of a bit-serial multiplier. Two unsigned operands of `WIDTH` bits arrive one bit per clock on two serial lines: the multiplicand X arrives most significant bit first and the multiplier Y arrives least significant bit first. The block keeps the bits already received in two history shift registers. In every accepted input cycle it emits one complete row of the partial-product matrix as a `2*WIDTH`-bit vector. The row holds every AND term that the newly arrived pair of bits makes available, together with the terms formed with the stored bits. Each bit sits at the vector position equal to its column weight, so a column accumulator downstream can add the rows without any further alignment.

Because one operand is fed from the top and the other from the bottom, the new X bit meets the old Y bits and the new Y bit meets the old X bits in the same cycle. The whole `WIDTH x WIDTH` matrix is therefore delivered in `WIDTH` rows, one per input cycle, and the last one is flagged. Adding the rows is left to the consumer.

Top module: `ser_pp_rowgen`

## Requirements
- R1: `row_valid` equals `in_valid` in the same cycle, with no register in between; while `in_valid` is low, `pp_row` is all zeros and `last_row` is low.
- R2: In every valid cycle, column `WIDTH-1` of `pp_row` equals `x_bit AND y_bit`.
- R3: In row r, for k = 0..r-1, column `WIDTH+k` equals the current `y_bit` AND the X bit of weight `WIDTH-r+k` received earlier in this product.
- R4: In row r, for k = 0..r-1, column `WIDTH-2-k` equals the current `x_bit` AND the Y bit of weight `r-1-k` received earlier in this product.
- R5: Row r has no set bit outside columns `WIDTH-1-r` to `WIDTH-1+r`; row 0 holds only the centre column, and column `2*WIDTH-1` is always zero.
- R6: The sum of the `WIDTH` rows of one product, each read as an unsigned number, equals X times Y.
- R7: `last_row` is high exactly with row `WIDTH-1`; the next valid cycle is row 0 of a new product without any `start`.
- R8: `start` discards all stored bits and sets the row index to 0; with `in_valid` high in the same cycle, that cycle is row 0 of a new product; without it, an unfinished product is aborted.
- R9: A cycle with `in_valid` low ignores `x_bit` and `y_bit` and leaves the stored bits and row index unchanged, so gaps in the stream do not alter any later row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new product; clears stored bits and row index |
| in_valid | input | 1 | `x_bit` and `y_bit` carry a new operand bit pair |
| x_bit | input | 1 | Multiplicand bit, most significant first |
| y_bit | input | 1 | Multiplier bit, least significant first |
| pp_row | output | 2*WIDTH | Partial-product row, bit c has weight 2^c |
| row_valid | output | 1 | `pp_row` holds a row this cycle |
| last_row | output | 1 | This row is row `WIDTH-1` of the product |

## Verification
The hardest situation to reach is a stored history that is stale at the moment a new product begins: a `start` arriving mid-product, either alone or together with a new first bit, and a product that follows another back to back with no `start` at all. The stimulus aborts products after a few rows with each kind of `start`, chains products without `start`, and inserts idle cycles carrying ones on both data lines, so that any leftover bit or lost index step shows up as a wrong column in a later row or as a wrong row sum.

// File: rtl/ser_pp_pkg.sv
`timescale 1ns/1ps
package ser_pp_pkg;
   localparam int unsigned MIN_OPERAND_WIDTH = 2;

   function automatic int unsigned index_bits(input int unsigned w);
      return (w <= 2) ? 1 : $clog2(w);
   endfunction
endpackage

// File: rtl/ser_pp_history.sv
`timescale 1ns/1ps
module ser_pp_history
   import ser_pp_pkg::*;
#(
   parameter int unsigned DEPTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             accept,
   input  logic             wrap,
   input  logic             din,
   output logic [DEPTH-1:0] view
);
   logic [DEPTH-1:0] hist_q;
   logic [DEPTH-1:0] shifted;

   assign view = restart ? '0 : hist_q;

   generate
      if (DEPTH == 1) begin : g_single
         assign shifted = din;
      end else begin : g_chain
         assign shifted = {view[DEPTH-2:0], din};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (accept) begin
         hist_q <= wrap ? '0 : shifted;
      end else if (restart) begin
         hist_q <= '0;
      end
   end

   // R8: a bare start leaves no stored bit behind
   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !accept) |=> (hist_q == '0));
   // R7: after the last row the history is empty for the next product
   assert_wrap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && wrap) |=> (hist_q == '0));
   // R9: idle cycles keep the stored bits
   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !restart) |=> $stable(hist_q));
endmodule

// File: rtl/ser_pp_row_index.sv
`timescale 1ns/1ps
module ser_pp_row_index
   import ser_pp_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IW   = index_bits(WIDTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          accept,
   output logic [IW-1:0] index,
   output logic          at_last
);
   localparam logic [IW-1:0] LAST_INDEX = IW'(WIDTH - 1);

   logic [IW-1:0] cnt_q;

   assign index   = restart ? '0 : cnt_q;
   assign at_last = (index == LAST_INDEX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (accept) begin
         cnt_q <= at_last ? '0 : IW'(index + 1'b1);
      end else if (restart) begin
         cnt_q <= '0;
      end
   end

   // R7: the index returns to zero after the last row
   assert_index_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && at_last) |=> (cnt_q == '0));
   // R7: inside a product every accepted row advances the index by one
   assert_index_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !at_last) |=> (cnt_q == IW'($past(index) + 1'b1)));
   // R9: no movement without a valid bit pair or start
   assert_index_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !restart) |=> $stable(cnt_q));
   // R8: a bare start puts the index at row 0
   assert_index_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !accept) |=> (cnt_q == '0));
endmodule

// File: rtl/ser_pp_row_former.sv
`timescale 1ns/1ps
module ser_pp_row_former #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned HD   = WIDTH - 1,
   localparam int unsigned RW   = 2 * WIDTH
) (
   input  logic          valid,
   input  logic          x_now,
   input  logic          y_now,
   input  logic [HD-1:0] x_hist,
   input  logic [HD-1:0] y_hist,
   output logic [RW-1:0] row
);
   always_comb begin
      row = '0;
      row[WIDTH-1] = valid & x_now & y_now;
      for (int k = 0; k < int'(HD); k++) begin
         row[WIDTH+k]   = valid & y_now & x_hist[k];
         row[WIDTH-2-k] = valid & x_now & y_hist[k];
      end
   end
endmodule

// File: rtl/ser_pp_rowgen.sv
`timescale 1ns/1ps
module ser_pp_rowgen
   import ser_pp_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned RW   = 2 * WIDTH,
   localparam int unsigned HD   = WIDTH - 1,
   localparam int unsigned IW   = index_bits(WIDTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          in_valid,
   input  logic          x_bit,
   input  logic          y_bit,
   output logic [RW-1:0] pp_row,
   output logic          row_valid,
   output logic          last_row
);
   generate
      if (WIDTH < MIN_OPERAND_WIDTH) begin : g_bad_width
         $error("ser_pp_rowgen: WIDTH must be at least 2");
      end
   endgenerate

   logic [IW-1:0] row_idx;
   logic          idx_last;
   logic [HD-1:0] x_view;
   logic [HD-1:0] y_view;

   ser_pp_row_index #(.WIDTH(WIDTH)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .accept  (in_valid),
      .index   (row_idx),
      .at_last (idx_last)
   );

   ser_pp_history #(.DEPTH(HD)) u_x_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .accept  (in_valid),
      .wrap    (idx_last),
      .din     (x_bit),
      .view    (x_view)
   );

   ser_pp_history #(.DEPTH(HD)) u_y_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .accept  (in_valid),
      .wrap    (idx_last),
      .din     (y_bit),
      .view    (y_view)
   );

   ser_pp_row_former #(.WIDTH(WIDTH)) u_former (
      .valid  (in_valid),
      .x_now  (x_bit),
      .y_now  (y_bit),
      .x_hist (x_view),
      .y_hist (y_view),
      .row    (pp_row)
   );

   assign row_valid = in_valid;
   assign last_row  = in_valid & idx_last;

   localparam logic [RW-1:0] CENTRE_ONLY = RW'(1) << (WIDTH - 1);

   // R1: a flagged last row is always a valid row
   assert_last_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      last_row |-> row_valid);
   // R1: no bit leaks out while no row is presented
   assert_idle_row_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !row_valid |-> (pp_row == '0));
   // R5: row r never holds more than 2r+1 terms
   assert_row_population_R5: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid |-> ($countones(pp_row) <= 2 * int'(row_idx) + 1));
   // R5, R8: the first row after start is the centre term alone
   assert_first_row_centre_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && start) |-> ((pp_row & ~CENTRE_ONLY) == '0));
endmodule

// File: tb/sim_ser_pp_rowgen.sv
`timescale 1ns/1ps
module sim_ser_pp_rowgen;
   localparam int W  = 8;
   localparam int RW = 2 * W;

   typedef struct packed {
      logic [RW-1:0] row;
      logic          last;
      logic          first;
      logic          chk;
      logic [RW-1:0] prod;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          in_valid = 1'b0;
   logic          x_bit = 1'b0;
   logic          y_bit = 1'b0;
   logic [RW-1:0] pp_row;
   logic          row_valid;
   logic          last_row;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t          exp_q[$];
   logic [W-1:0]  xa;
   logic [W-1:0]  ya;
   int            m_r = 0;
   logic [RW-1:0] acc = '0;

   always #10 clk = ~clk;

   ser_pp_rowgen #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .x_bit(x_bit), .y_bit(y_bit), .pp_row(pp_row),
      .row_valid(row_valid), .last_row(last_row)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [RW-1:0] act, input logic [RW-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // driver: one input cycle, pushes the expected row when a pair is sent
   task automatic cycle(input bit s, input bit v, input bit xb, input bit yb,
                        input bit chk, input logic [RW-1:0] prod);
      exp_t e;
      @(posedge clk);
      #2;
      start = s; in_valid = v; x_bit = xb; y_bit = yb;
      if (s) begin
         m_r = 0; xa = '0; ya = '0;
      end
      if (v) begin
         xa[W-1-m_r] = xb;
         ya[m_r]     = yb;
         e = '0;
         for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++)
               if (((j > W-1-i) ? j : W-1-i) == m_r)
                  e.row[i+j] = xa[i] & ya[j];
         e.last  = (m_r == W-1);
         e.first = (m_r == 0);
         e.chk   = chk;
         e.prod  = prod;
         exp_q.push_back(e);
         if (m_r == W-1) begin
            m_r = 0; xa = '0; ya = '0;
         end else begin
            m_r++;
         end
      end
   endtask

   task automatic product(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit use_start, input int gap);
      for (int r = 0; r < W; r++) begin
         if (gap > 0 && (r % gap) == gap - 1)
            cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);   // R9: idle with ones on the data lines
         cycle(use_start && r == 0, 1'b1, a[W-1-r], b[r], r == W-1, RW'(a) * RW'(b));
      end
   endtask

   task automatic partial(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit use_start, input int rows);
      for (int r = 0; r < rows; r++)
         cycle(use_start && r == 0, 1'b1, a[W-1-r], b[r], 1'b0, '0);
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (row_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "row without a sent pair", pp_row, '0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               // R2 R3 R4 R5: every column of the row against the matrix model
               check(pp_row == e.row, "R3", "row columns (R2 R4 R5)", pp_row, e.row);
               check(last_row == e.last, "R7", "last_row flag", RW'(last_row), RW'(e.last));
               if (e.first) acc = '0;
               acc = acc + pp_row;
               if (e.last && e.chk)
                  check(acc == e.prod, "R6", "sum of rows", acc, e.prod);
            end
         end else begin
            check(pp_row == '0 && !last_row, "R1", "idle outputs", pp_row, '0);
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      xa = '0; ya = '0;
      #15;
      check(row_valid == 1'b0 && pp_row == '0, "R1", "reset state", pp_row, '0);
      #20 rst_n = 1'b1;

      product(8'hFF, 8'hFF, 1'b1, 0);          // all ones
      product(8'h00, 8'hA5, 1'b0, 0);          // R7: back to back, no start
      product(8'hAA, 8'h55, 1'b0, 3);          // R9: gaps
      product(8'h80, 8'h01, 1'b1, 0);          // single centre term
      product(8'h01, 8'h80, 1'b0, 2);
      partial(8'hFF, 8'hFF, 1'b1, 3);          // R8: abort by start with valid
      product(8'h3C, 8'hC3, 1'b1, 0);
      partial(8'hFF, 8'hFF, 1'b0, 5);          // R8: abort by bare start
      cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0);
      product(8'h96, 8'h69, 1'b0, 0);
      for (int n = 0; n < 40; n++)
         product(W'($urandom), W'($urandom), n[0], n % 4);
      cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      check(exp_q.size() == 0, "R1", "rows outstanding", RW'(exp_q.size()), '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule